// File: doc/BRIEF.md
# Grouped Two-Level Interrupt Expander

This block gathers a large field of peripheral interrupt requests, organised as groups of eight sources each, and folds them onto one CPU interrupt request per group line. Every group keeps its own latched request flags, a per-source enable mask and a ready/blocked acknowledge latch. A group whose acknowledge latch is ready and that has at least one enabled pending flag raises its bit in a CPU-level flag register. The CPU-level flags are gated by a CPU-level enable mask and by a global mask bit. The winning request is presented as a single interrupt line together with a vector index.

When the CPU signals that it has taken the interrupt, the controller clears the chosen source flag and the chosen CPU-level flag, and it blocks the group until software re-arms it through the acknowledge register. Unused source slots serve as software interrupts: software sets their flag bits by writing the group flag register. One group line has no hardware sources wired at all. A mode input decides what happens when a software write to a group flag register lands in the same cycle as a hardware request. In the protected mode the hardware request survives. In the raw mode the write overwrites the flag and the request is lost, so software can study that race.

Top module: `girq_ctrl`

## Requirements
- R1: After reset all group flags, group enables, acknowledge latches, CPU-level flags and CPU-level enables read 0, the global mask reads 1 (masked), and `cpu_irq` is low.
- R2: A one-cycle pulse on `src_req[g*8+p]` sets flag bit p of group g. When enable bit p of that group is set, the group's acknowledge latch is ready, CPU enable bit g is set and the global mask is 0, `cpu_irq` goes high and `cpu_vec` equals g*8+p (position 0 = lowest index).
- R3: While CPU enable bit g is 0 or the global mask is 1, group g raises no `cpu_irq`. The request stays pending and appears once the gate opens.
- R4: While the acknowledge latch of group g is set, a new enabled request in that group does not raise `cpu_irq`.
- R5: `irq_take` sampled high while `cpu_irq` is high clears the source flag named by `cpu_vec` and CPU-level flag bit g, and it sets acknowledge bit g. Acknowledge bits read as 1 = blocked.
- R6: Writing the acknowledge register clears every acknowledge bit whose data bit is 1. Bits written 0 are unchanged, so a write of 0 leaves a blocked group blocked.
- R7: Within a group the lowest enabled pending position wins. Across groups the lowest-numbered line wins, and a losing group's request follows after the winner is taken.
- R8: A software write of a group flag register sets flags that forward like hardware ones. Group 10 ignores its `src_req` inputs, so only software can set its flags.
- R9: With `raw_wr_mode` = 0, a hardware request in the same cycle as a flag-register write (or a take clear) of the same bit leaves that bit set.
- R10: With `raw_wr_mode` = 1, a flag-register write in the same cycle as a hardware request stores the written value, and the request is lost.
- R11: Register map (word addresses): group g flags at g, group g enables at 16+g, acknowledge at 32, CPU flags at 33 (read only), CPU enables at 34, global mask (bit 0) at 35. `bus_rdata` is valid one cycle after `bus_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 96 | Peripheral request pulses, bit g*8+p |
| raw_wr_mode | input | 1 | 1 = flag writes overwrite same-cycle hardware requests |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_take | input | 1 | CPU has taken the presented interrupt |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |
| cpu_vec | output | 7 | Registered vector index g*8+p |

## Verification
The hardest situation to reach from the ports is a register write and a hardware request that land on the same bit in the same clock edge. The bench drives the bus write strobe and the request pulse from the same negative edge, so both are sampled together, and then reads the flag back in each mode. The acknowledge blocking is also hard to observe, because it only shows as an interrupt that fails to appear. The bench therefore re-arms the blocked group with a zero write first and then with a one write, and checks that the request appears only after the second.

// File: rtl/girq_pkg.sv
package girq_pkg;
  localparam int GRP_N_DEF = 12;
  localparam int SRC_N_DEF = 8;
  localparam int DW_DEF    = 16;
  localparam int AW_DEF    = 6;

  // word address map
  localparam int FLAG_BASE = 0;
  localparam int EN_BASE   = 16;
  localparam int ACK_ADDR  = 32;
  localparam int CFLG_ADDR = 33;
  localparam int CEN_ADDR  = 34;
  localparam int MASK_ADDR = 35;

  // group with no hardware sources wired
  localparam int SW_GRP_DEF = 10;
endpackage

// File: rtl/girq_group.sv
module girq_group #(
  parameter int SRC_N   = 8,
  parameter bit SW_ONLY = 1'b0,
  localparam int PW     = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] hw_set,
  input  logic             raw_mode,
  input  logic             flag_we,
  input  logic             en_we,
  input  logic [SRC_N-1:0] wdata,
  input  logic             ack_clr,
  input  logic             take_hit,
  input  logic [PW-1:0]    take_pos,
  output logic [SRC_N-1:0] flag_q,
  output logic [SRC_N-1:0] en_q,
  output logic             ack_q,
  output logic             fwd,
  output logic [PW-1:0]    pos_nxt
);
  logic [SRC_N-1:0] hw_eff;
  logic [SRC_N-1:0] take_mask;
  logic [SRC_N-1:0] flag_nxt;
  logic [SRC_N-1:0] en_nxt;
  logic [SRC_N-1:0] pend_nxt;
  logic             ack_nxt;

  generate
    if (SW_ONLY) begin : g_sw
      assign hw_eff = '0;
    end else begin : g_hw
      assign hw_eff = hw_set;
    end
  endgenerate

  always_comb begin
    take_mask = '0;
    if (take_hit) take_mask[take_pos] = 1'b1;
  end

  always_comb begin
    if (flag_we) flag_nxt = raw_mode ? wdata : (wdata | hw_eff);
    else         flag_nxt = (flag_q & ~take_mask) | hw_eff;
    en_nxt  = en_we ? wdata : en_q;
    ack_nxt = take_hit ? 1'b1 : (ack_clr ? 1'b0 : ack_q);
  end

  assign pend_nxt = flag_nxt & en_nxt;
  assign fwd      = (|(flag_q & en_q)) & ~ack_q;

  always_comb begin
    pos_nxt = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pend_nxt[i]) pos_nxt = PW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      en_q   <= en_nxt;
      ack_q  <= ack_nxt;
    end
  end
endmodule

// File: rtl/girq_arb.sv
module girq_arb #(
  parameter int GRP_N = 12,
  parameter int PW    = 3,
  localparam int GW   = $clog2(GRP_N),
  localparam int VW   = GW + PW
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [GRP_N-1:0]          grp_fwd,
  input  logic [GRP_N-1:0][PW-1:0]  grp_pos,
  input  logic [GRP_N-1:0]          take_vec,
  input  logic                      en_we,
  input  logic                      mask_we,
  input  logic [GRP_N-1:0]          wdata,
  output logic [GRP_N-1:0]          cflag_q,
  output logic [GRP_N-1:0]          cen_q,
  output logic                      gmask_q,
  output logic                      irq_q,
  output logic [VW-1:0]             vec_q
);
  logic [GRP_N-1:0] cflag_nxt;
  logic [GRP_N-1:0] cen_nxt;
  logic             gmask_nxt;
  logic [GRP_N-1:0] req_nxt;
  logic [GW-1:0]    win;

  always_comb begin
    cflag_nxt = (cflag_q | grp_fwd) & ~take_vec;
    cen_nxt   = en_we ? wdata : cen_q;
    gmask_nxt = mask_we ? wdata[0] : gmask_q;
    req_nxt   = gmask_nxt ? '0 : (cflag_nxt & cen_nxt);
  end

  always_comb begin
    win = '0;
    for (int g = GRP_N - 1; g >= 0; g--) begin
      if (req_nxt[g]) win = GW'(g);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cflag_q <= '0;
      cen_q   <= '0;
      gmask_q <= 1'b1;
      irq_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      cflag_q <= cflag_nxt;
      cen_q   <= cen_nxt;
      gmask_q <= gmask_nxt;
      irq_q   <= |req_nxt;
      vec_q   <= {win, grp_pos[win]};
    end
  end
endmodule

// File: rtl/girq_ctrl.sv
module girq_ctrl
  import girq_pkg::*;
#(
  parameter int GRP_N  = GRP_N_DEF,
  parameter int SRC_N  = SRC_N_DEF,
  parameter int DW     = DW_DEF,
  parameter int AW     = AW_DEF,
  parameter int SW_GRP = SW_GRP_DEF,
  localparam int PW    = $clog2(SRC_N),
  localparam int GW    = $clog2(GRP_N),
  localparam int VW    = GW + PW,
  localparam int NSRC  = GRP_N * SRC_N
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic            raw_wr_mode,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            irq_take,
  output logic            cpu_irq,
  output logic [VW-1:0]   cpu_vec
);
  logic [GRP_N-1:0][SRC_N-1:0] flag_all;
  logic [GRP_N-1:0][SRC_N-1:0] en_all;
  logic [GRP_N-1:0][PW-1:0]    pos_all;
  logic [GRP_N-1:0]            ack_all;
  logic [GRP_N-1:0]            fwd_all;
  logic [GRP_N-1:0]            take_vec;
  logic [GRP_N-1:0]            cflag;
  logic [GRP_N-1:0]            cen;
  logic                        gmask;
  logic                        take_ok;
  logic                        ack_we;
  logic [GW-1:0]               take_grp;
  logic [PW-1:0]               take_pos;

  assign take_ok  = irq_take & cpu_irq;
  assign take_grp = cpu_vec[VW-1:PW];
  assign take_pos = cpu_vec[PW-1:0];
  assign ack_we   = bus_we && (bus_addr == AW'(ACK_ADDR));

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic flag_we_g, en_we_g;
    assign flag_we_g   = bus_we && (bus_addr == AW'(FLAG_BASE + g));
    assign en_we_g     = bus_we && (bus_addr == AW'(EN_BASE + g));
    assign take_vec[g] = take_ok && (take_grp == GW'(g));

    girq_group #(
      .SRC_N  (SRC_N),
      .SW_ONLY(g == SW_GRP)
    ) u_grp (
      .clk     (clk),
      .rst     (rst),
      .hw_set  (src_req[g*SRC_N +: SRC_N]),
      .raw_mode(raw_wr_mode),
      .flag_we (flag_we_g),
      .en_we   (en_we_g),
      .wdata   (bus_wdata[SRC_N-1:0]),
      .ack_clr (ack_we && bus_wdata[g]),
      .take_hit(take_vec[g]),
      .take_pos(take_pos),
      .flag_q  (flag_all[g]),
      .en_q    (en_all[g]),
      .ack_q   (ack_all[g]),
      .fwd     (fwd_all[g]),
      .pos_nxt (pos_all[g])
    );
  end

  girq_arb #(
    .GRP_N(GRP_N),
    .PW   (PW)
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .grp_fwd (fwd_all),
    .grp_pos (pos_all),
    .take_vec(take_vec),
    .en_we   (bus_we && (bus_addr == AW'(CEN_ADDR))),
    .mask_we (bus_we && (bus_addr == AW'(MASK_ADDR))),
    .wdata   (bus_wdata[GRP_N-1:0]),
    .cflag_q (cflag),
    .cen_q   (cen),
    .gmask_q (gmask),
    .irq_q   (cpu_irq),
    .vec_q   (cpu_vec)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (bus_addr == AW'(FLAG_BASE + g)) rd_mux = DW'(flag_all[g]);
      if (bus_addr == AW'(EN_BASE + g))   rd_mux = DW'(en_all[g]);
    end
    if (bus_addr == AW'(ACK_ADDR))  rd_mux = DW'(ack_all);
    if (bus_addr == AW'(CFLG_ADDR)) rd_mux = DW'(cflag);
    if (bus_addr == AW'(CEN_ADDR))  rd_mux = DW'(cen);
    if (bus_addr == AW'(MASK_ADDR)) rd_mux = DW'(gmask);
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

module girq_ctrl_chk #(
  parameter int GRP_N = 12,
  parameter int VW    = 7,
  parameter int PW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_irq,
  input logic [VW-1:0]    cpu_vec,
  input logic             take_ok,
  input logic [GRP_N-1:0] ack_all,
  input logic [GRP_N-1:0] cflag,
  input logic [GRP_N-1:0] cen,
  input logic             gmask
);
  localparam int GW = VW - PW;
  logic [GW-1:0] vg;
  assign vg = cpu_vec[VW-1:PW];

  p_irq_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> !gmask);

  p_vec_range_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (int'(vg) < GRP_N));

  p_irq_src_live_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && int'(vg) < GRP_N) |-> (cflag[vg] && cen[vg]));

  p_take_acks_r5: assert property (@(posedge clk) disable iff (rst)
    (take_ok && int'(vg) < GRP_N) |=> ack_all[$past(vg)]);

  p_take_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (take_ok && int'(vg) < GRP_N) |=> !cflag[$past(vg)]);
endmodule

bind girq_ctrl girq_ctrl_chk #(.GRP_N(GRP_N), .VW(VW), .PW(PW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cpu_irq(cpu_irq),
  .cpu_vec(cpu_vec),
  .take_ok(take_ok),
  .ack_all(ack_all),
  .cflag  (cflag),
  .cen    (cen),
  .gmask  (gmask)
);

// File: tb/girq_ctrl_tb.sv
module girq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NSRC-1:0] src_req = '0;
  logic        raw_wr_mode = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_take = 1'b0;
  logic        cpu_irq;
  logic [6:0]  cpu_vec;

  int total = 0, bad = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  girq_ctrl u_dut (
    .clk(clk), .rst(rst), .src_req(src_req), .raw_wr_mode(raw_wr_mode),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_take(irq_take), .cpu_irq(cpu_irq), .cpu_vec(cpu_vec)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = 6'(a);
    @(negedge clk);
    bus_re = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic pulse(int g, int pmask);
    @(negedge clk);
    for (int p = 0; p < 8; p++) src_req[g*8+p] = pmask[p];
    @(negedge clk);
    src_req = '0;
  endtask

  // driver side of the scoreboard: push expected vector, then take
  task automatic take(int exp_vec);
    exp_q.push_back(exp_vec);
    @(negedge clk);
    irq_take = 1'b1;
    @(negedge clk);
    irq_take = 1'b0;
  endtask

  // flag write colliding with a hardware request on the same edge
  task automatic collide(int g, int wval, int p);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'(g); bus_wdata = 16'(wval);
    src_req[g*8+p] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; src_req = '0;
  endtask

  // monitor side of the scoreboard
  always @(posedge clk) begin
    if (!rst && irq_take && cpu_irq) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R5 take with no expected vector actual=%0d expected=none", cpu_vec);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(cpu_vec) != e) begin
          bad++;
          $display("FAIL R2/R7 taken vector actual=%0d expected=%0d", cpu_vec, e);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 irq", int'(cpu_irq), 0);
    rd(32, d); chk("R1 ack", d, 0);
    rd(35, d); chk("R1 mask", d, 1);
    rd(2, d);  chk("R1 flag g2", d, 0);
    rd(34, d); chk("R11 cen readback", d, 0);

    wr(34, 'hFFF);
    wr(35, 0);
    wr(16+2, 'h20);

    // R2 forward g2 p5
    pulse(2, 'h20);
    idle(3);
    chk("R2 irq", int'(cpu_irq), 1);
    chk("R2 vec", int'(cpu_vec), 21);
    take(21);
    idle(2);
    chk("R5 irq after take", int'(cpu_irq), 0);
    rd(32, d); chk("R5 ack set", d, 'h004);
    rd(2, d);  chk("R5 flag cleared", d, 0);
    rd(33, d); chk("R5 cpu flag cleared", d, 0);

    // R4 blocked group
    wr(16+2, 'h22);
    pulse(2, 'h02);
    idle(3);
    chk("R4 blocked", int'(cpu_irq), 0);
    // R6 zero write does nothing
    wr(32, 0);
    idle(3);
    chk("R6 zero write", int'(cpu_irq), 0);
    rd(32, d); chk("R6 ack kept", d, 'h004);
    wr(32, 'h004);
    idle(3);
    chk("R6 rearm irq", int'(cpu_irq), 1);
    chk("R6 rearm vec", int'(cpu_vec), 17);
    take(17);
    wr(32, 'h004);

    // R7 within group
    wr(16+4, 'h48);
    pulse(4, 'h48);
    idle(3);
    chk("R7 in-group vec", int'(cpu_vec), 35);
    take(35);
    wr(32, 'h010);
    idle(3);
    chk("R7 next in-group vec", int'(cpu_vec), 38);
    take(38);
    wr(32, 'h010);

    // R7 across groups
    wr(16+0, 'h80);
    wr(16+1, 'h80);
    @(negedge clk);
    src_req[7] = 1'b1; src_req[15] = 1'b1;
    @(negedge clk);
    src_req = '0;
    idle(3);
    chk("R7 cross-group vec", int'(cpu_vec), 7);
    take(7);
    idle(2);
    chk("R7 loser follows irq", int'(cpu_irq), 1);
    chk("R7 loser follows vec", int'(cpu_vec), 15);
    take(15);
    wr(32, 'h003);

    // R3 gating
    wr(34, 'hFDF);
    wr(16+5, 'h01);
    pulse(5, 'h01);
    idle(3);
    chk("R3 cen gate", int'(cpu_irq), 0);
    wr(34, 'hFFF);
    idle(3);
    chk("R3 gate open vec", int'(cpu_vec), 40);
    wr(35, 1);
    idle(2);
    chk("R3 mask gate", int'(cpu_irq), 0);
    wr(35, 0);
    idle(2);
    chk("R3 unmask irq", int'(cpu_irq), 1);
    take(40);
    wr(32, 'h020);

    // R8 software group 10
    wr(16+10, 'h10);
    pulse(10, 'hFF);
    idle(3);
    rd(10, d); chk("R8 g10 ignores hw", d, 0);
    chk("R8 g10 no irq", int'(cpu_irq), 0);
    wr(10, 'h10);
    idle(3);
    chk("R8 sw irq", int'(cpu_irq), 1);
    chk("R8 sw vec", int'(cpu_vec), 84);
    take(84);
    wr(32, 'h400);

    // R9 protected collision
    raw_wr_mode = 1'b0;
    collide(3, 0, 2);
    idle(1);
    rd(3, d); chk("R9 hw set survives", d, 'h04);
    wr(3, 0);
    // R10 raw collision
    raw_wr_mode = 1'b1;
    collide(3, 0, 2);
    idle(1);
    rd(3, d); chk("R10 hw set lost", d, 0);
    raw_wr_mode = 1'b0;

    idle(2);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule